// File: doc/BRIEF.md
# Word-Parallel Multi-Column LFSR Generator

This block produces a fresh pseudo-random word on every enabled clock. Its state is a chain of word-wide stages. On each step the stages at two tap positions are XORed bit by bit, the result enters as the new head stage, and every other stage moves one position further down the chain. As a result, each bit column of the chain is an independent Fibonacci shift register of length STAGES. Every output bit changes on every step, rather than one new bit entering while the rest of the pattern slides over.

The stage count and the two tap positions are fixed when the block is built. The defaults are 31 stages with taps at stages 7 and 31 (1-based), which makes each column a maximal-length sequence. A longer chain costs only flip-flops: the feedback is always a single two-input XOR per column, whatever the length. The stages can be seeded one at a time through a write strobe with an index. A column that is entirely zero never leaves zero, so a status flag reports whenever any column across the whole chain is all zeros.

Top module: `vlfsr_gen`

## Requirements
- R1: When rst is sampled high on a clock edge, the output word becomes 0, the head stage (index 0) becomes all ones and all other stages become 0, so col_zero reads 0 after reset.
- R2: On an enabled step (en high, seed_we low), rnd_out takes the new head stage one cycle later. The new head stage is the bitwise XOR of stage TAP_A and stage TAP_B (1-based, indices TAP_A-1 and TAP_B-1) as they were before the step.
- R3: On an enabled step, the stage at index k takes the old value of index k-1 for every k from 1 to STAGES-1.
- R4: With en low and seed_we low, all stages and rnd_out hold their values.
- R5: With seed_we high, the stage at index seed_idx takes seed_data, and no stage advances even if en is high. rnd_out holds its value.
- R6: A seed write whose seed_idx is STAGES or greater changes no stage.
- R7: col_zero is 1 exactly when at least one bit column (the same bit position in every stage) is zero in all stages. It reflects the stage contents of the current cycle.
- R8: A column that is all zero stays all zero across enabled steps: its bit in rnd_out stays 0 and col_zero stays 1 until a seed write fills that column.
- R9: Each column reproduces the output bit sequence of a single-bit Fibonacci shift register of STAGES cells with feedback from cells TAP_A and TAP_B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| seed_we | input | 1 | Seed write strobe; blocks stepping |
| seed_idx | input | IDX_W (5) | Stage index of the seed write, 0-based |
| seed_data | input | WIDTH (8) | Word written into the addressed stage |
| rnd_out | output | WIDTH (8) | Registered pseudo-random word |
| col_zero | output | 1 | High while any bit column is all zeros |

## Verification
The generator is first run from its reset seed, which has only one stage set. This shows whether the tap positions and the shift order are right while most of the chain is still empty. It is then run from a dense seed written into every stage with en held high, which separates write precedence from stepping and exercises all columns at once. A write to an index past the chain end must leave the later output stream unchanged. A seed with one column cleared everywhere must keep that output bit at 0 and the flag raised until a single write fills the column again. A bit-level single-register model of column 0 runs beside the word-level model to confirm that the columns match the scalar sequence.

// File: rtl/vlfsr_pkg.sv
package vlfsr_pkg;

   // Width of an index able to address n stages (at least one bit).
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Nonzero when the tap configuration is usable.
   function automatic bit taps_ok(input int n, input int ta, input int tb);
      return (ta >= 1) && (ta < tb) && (tb <= n);
   endfunction

endpackage

// File: rtl/vlfsr_chain.sv
module vlfsr_chain #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 31,
   parameter int IDX_W  = 5
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           advance,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [WIDTH-1:0]               wr_data,
   input  logic [WIDTH-1:0]               fb_in,
   output logic [STAGES-1:0][WIDTH-1:0]   stage_bus
);

   localparam logic [WIDTH-1:0] HEAD_SEED = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BODY_SEED = {WIDTH{1'b0}};

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] shift_src;
      logic [WIDTH-1:0] cell_q;
      logic             hit;

      if (s == 0) begin : g_head
         assign shift_src = fb_in;
      end else begin : g_body
         assign shift_src = stage_bus[s-1];
      end

      assign hit = (wr_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (rst) begin
            cell_q <= (s == 0) ? HEAD_SEED : BODY_SEED;
         end else if (wr_en) begin
            if (hit) cell_q <= wr_data;
         end else if (advance) begin
            cell_q <= shift_src;
         end
      end

      assign stage_bus[s] = cell_q;
   end

   // R3: the tail stage takes what its neighbour held before the step
   assert_tail_shift_R3 : assert property (@(posedge clk) disable iff (rst)
      (advance && !wr_en) |=> (stage_bus[STAGES-1] == $past(stage_bus[STAGES-2])));

   // R3: the second stage takes the old head
   assert_head_shift_R3 : assert property (@(posedge clk) disable iff (rst)
      (advance && !wr_en) |=> (stage_bus[1] == $past(stage_bus[0])));

   // R6: a write past the chain end leaves every stage alone
   assert_oob_write_R6 : assert property (@(posedge clk) disable iff (rst)
      (wr_en && (int'(wr_idx) >= STAGES)) |=> $stable(stage_bus));

   // R4: no write and no step keeps the chain frozen
   assert_idle_hold_R4 : assert property (@(posedge clk) disable iff (rst)
      (!advance && !wr_en) |=> $stable(stage_bus));

endmodule

// File: rtl/vlfsr_tap_xor.sv
module vlfsr_tap_xor #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 31,
   parameter int TAP_A  = 7,
   parameter int TAP_B  = 31
) (
   input  logic [STAGES-1:0][WIDTH-1:0] stage_bus,
   output logic [WIDTH-1:0]             fb_out
);

   localparam int IA = TAP_A - 1;
   localparam int IB = TAP_B - 1;

   assign fb_out = stage_bus[IA] ^ stage_bus[IB];

endmodule

// File: rtl/vlfsr_col_watch.sv
module vlfsr_col_watch #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 31
) (
   input  logic [STAGES-1:0][WIDTH-1:0] stage_bus,
   output logic                         any_dead
);

   logic [WIDTH-1:0] col_live;

   for (genvar c = 0; c < WIDTH; c++) begin : g_col
      always_comb begin
         col_live[c] = 1'b0;
         for (int s = 0; s < STAGES; s++) begin
            col_live[c] = col_live[c] | stage_bus[s][c];
         end
      end
   end

   assign any_dead = ~&col_live;

endmodule

// File: rtl/vlfsr_gen.sv
module vlfsr_gen #(
   parameter int  WIDTH  = 8,
   parameter int  STAGES = 31,
   parameter int  TAP_A  = 7,
   parameter int  TAP_B  = 31,
   localparam int IDX_W  = vlfsr_pkg::idx_width(STAGES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             seed_we,
   input  logic [IDX_W-1:0] seed_idx,
   input  logic [WIDTH-1:0] seed_data,
   output logic [WIDTH-1:0] rnd_out,
   output logic             col_zero
);

   if (WIDTH < 1) begin : g_bad_width
      $error("vlfsr_gen: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_depth
      $error("vlfsr_gen: STAGES must be at least 2");
   end
   if (!vlfsr_pkg::taps_ok(STAGES, TAP_A, TAP_B)) begin : g_bad_taps
      $error("vlfsr_gen: taps need 1 <= TAP_A < TAP_B <= STAGES");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_bus;
   logic [WIDTH-1:0]             fb_word;
   logic                         step;
   logic [WIDTH-1:0]             out_q;

   assign step = en & ~seed_we;

   vlfsr_chain #(
      .WIDTH (WIDTH),
      .STAGES(STAGES),
      .IDX_W (IDX_W)
   ) u_chain (
      .clk      (clk),
      .rst      (rst),
      .advance  (step),
      .wr_en    (seed_we),
      .wr_idx   (seed_idx),
      .wr_data  (seed_data),
      .fb_in    (fb_word),
      .stage_bus(stage_bus)
   );

   vlfsr_tap_xor #(
      .WIDTH (WIDTH),
      .STAGES(STAGES),
      .TAP_A (TAP_A),
      .TAP_B (TAP_B)
   ) u_taps (
      .stage_bus(stage_bus),
      .fb_out   (fb_word)
   );

   vlfsr_col_watch #(
      .WIDTH (WIDTH),
      .STAGES(STAGES)
   ) u_watch (
      .stage_bus(stage_bus),
      .any_dead (col_zero)
   );

   always_ff @(posedge clk) begin
      if (rst)       out_q <= '0;
      else if (step) out_q <= fb_word;
   end

   assign rnd_out = out_q;

   // R2: output after a step equals the XOR of the old tap stages
   assert_step_value_R2 : assert property (@(posedge clk) disable iff (rst)
      step |=> (rnd_out == $past(stage_bus[TAP_A-1] ^ stage_bus[TAP_B-1])));

   // R2: the new head stage equals the word just presented
   assert_head_matches_out_R2 : assert property (@(posedge clk) disable iff (rst)
      step |=> (stage_bus[0] == rnd_out));

   // R4: output frozen while idle
   assert_idle_out_R4 : assert property (@(posedge clk) disable iff (rst)
      (!en && !seed_we) |=> $stable(rnd_out));

   // R5: output frozen during a seed write, enable or not
   assert_seed_out_R5 : assert property (@(posedge clk) disable iff (rst)
      seed_we |=> $stable(rnd_out));

   // R7: with every column alive, stepping keeps them alive
   assert_alive_kept_R7 : assert property (@(posedge clk) disable iff (rst)
      (step && !col_zero) |=> !col_zero);

   // R8: a dead column cannot revive by stepping
   assert_dead_kept_R8 : assert property (@(posedge clk) disable iff (rst)
      (step && col_zero) |=> col_zero);

endmodule

// File: tb/vlfsr_gen_bench.sv
`timescale 1ns/1ps
module vlfsr_gen_bench;

   localparam int W  = 8;
   localparam int N  = 31;
   localparam int TA = 7;
   localparam int TB = 31;
   localparam int IW = 5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic          seed_we = 1'b0;
   logic [IW-1:0] seed_idx = '0;
   logic [W-1:0]  seed_data = '0;
   logic [W-1:0]  rnd_out;
   logic          col_zero;

   vlfsr_gen u_vlfsr_gen (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .seed_we  (seed_we),
      .seed_idx (seed_idx),
      .seed_data(seed_data),
      .rnd_out  (rnd_out),
      .col_zero (col_zero)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // word-level queue model
   logic [W-1:0] q_mdl [$];
   logic [W-1:0] exp_out;
   // bit-level single register for column 0 (R9)
   logic [N-1:0] breg;
   logic         bexp;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit model_dead();
      bit dead = 0;
      for (int c = 0; c < W; c++) begin
         bit live = 0;
         foreach (q_mdl[s]) live |= q_mdl[s][c];
         if (!live) dead = 1;
      end
      return dead;
   endfunction

   task automatic model_edge();
      if (rst) begin
         q_mdl.delete();
         q_mdl.push_back('1);
         for (int s = 1; s < N; s++) q_mdl.push_back('0);
         exp_out = '0;
         breg = '0; breg[0] = 1'b1; bexp = 1'b0;
      end else if (seed_we) begin
         if (int'(seed_idx) < N) begin
            q_mdl[seed_idx] = seed_data;
            breg[seed_idx]  = seed_data[0];
         end
      end else if (en) begin
         logic [W-1:0] nw;
         logic         nb;
         nw = q_mdl[TA-1] ^ q_mdl[TB-1];
         void'(q_mdl.pop_back());
         q_mdl.push_front(nw);
         exp_out = nw;
         nb = breg[TA-1] ^ breg[TB-1];
         breg = {breg[N-2:0], nb};
         bexp = nb;
      end
   endtask

   task automatic cyc(input string req);
      @(posedge clk);
      model_edge();
      #1;
      check(req, int'(rnd_out), int'(exp_out));
      check("R7", int'(col_zero), int'(model_dead()));
      check("R9", int'(rnd_out[0]), int'(bexp));
   endtask

   task automatic steps(input int n, input string req);
      en = 1'b1; seed_we = 1'b0;
      repeat (n) cyc(req);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      rst = 1'b1;
      cyc("R1");
      cyc("R1");
      check("R1", int'(rnd_out), 0);
      check("R1", int'(col_zero), 0);
      rst = 1'b0;

      // R2 / R3: run from the sparse reset seed
      steps(45, "R2");
      steps(30, "R3");

      // R4: idle hold
      en = 1'b0;
      repeat (6) cyc("R4");

      // R5: dense seed with enable held high
      en = 1'b1; seed_we = 1'b1;
      for (int s = 0; s < N; s++) begin
         seed_idx  = IW'(s);
         seed_data = W'((s * 37 + 11) ^ (s << 3));
         cyc("R5");
      end
      steps(90, "R2");

      // R6: write past the chain end, then prove nothing changed
      seed_we = 1'b1; seed_idx = IW'(31); seed_data = 8'hA5;
      cyc("R6");
      steps(40, "R6");

      // R7 / R8: clear column 3 everywhere
      seed_we = 1'b1; en = 1'b0;
      for (int s = 0; s < N; s++) begin
         seed_idx  = IW'(s);
         seed_data = W'((s * 53 + 7) & 8'hF7);
         cyc("R7");
      end
      check("R7", int'(col_zero), 1);
      steps(70, "R8");
      check("R8", int'(rnd_out[3]), 0);
      check("R8", int'(col_zero), 1);

      // R7: one write revives the column
      seed_we = 1'b1; seed_idx = IW'(12); seed_data = 8'h08;
      cyc("R7");
      check("R7", int'(col_zero), 0);
      steps(50, "R2");

      // R1: reset mid-run
      rst = 1'b1; en = 1'b1;
      cyc("R1");
      rst = 1'b0;
      check("R1", int'(rnd_out), 0);
      steps(20, "R2");

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule